// File: doc/BRIEF.md
# Serial Channel External/Status Interrupt Latch

This block tracks the external and status conditions of one serial channel and decides when they raise an external/status interrupt. It watches an asynchronous carrier-detect pin, a zero-count level from the baud rate generator, the transmit buffer and receive FIFO occupancy, and a flag that is high while CRC is being sent. It presents a four-bit status word and one interrupt-pending flag.

While an interrupt is pending, the carrier-detect latch is closed and keeps the level it captured when the interrupt was raised. The host reads the status and then issues a service-done pulse. That pulse clears the pending flag and reopens the latch. Any enabled source that changed while the latch was closed then raises a new interrupt on the following clock.

The zero-count bit is never latched. A zero-count rising edge that arrives while another interrupt is pending is held back until service ends. It is dropped if the zero-count condition no longer holds by then.

Top module: `ext_stat_latch`

## Requirements
- R1: After synchronous reset, `extPending` is 0 and `statusReg` is 4'b0100: transmit-empty is 1 and the other bits are 0. This assumes the carrier pin is low during reset.
- R2: With `carrierIe` low, status bit 3 follows the carrier pin two clocks after a change, through the two-stage synchronizer. A carrier change never sets `extPending` in this case.
- R3: With `carrierIe` high and nothing pending, a carrier pin change sets `extPending` three clocks after the change. From that clock on, bit 3 shows the new level.
- R4: With `carrierIe` high and `extPending` set, bit 3 holds the level captured when the interrupt was raised, whatever the pin does.
- R5: Status bit 1 equals `zeroCntIe & zeroCnt` of the previous clock. It is not latched, so it falls as soon as the condition ends, even while an interrupt is pending.
- R6: When nothing is pending, a rising edge of `zeroCntIe & zeroCnt` sets `extPending` on the next clock.
- R7: A zero-count rising edge that occurs while `extPending` is set raises no interrupt at that time. If the condition still holds after service ends, `extPending` is set again on the second clock after the `svcDone` pulse.
- R8: A deferred zero-count edge whose condition has ended by the time service completes raises no interrupt.
- R9: `svcDone` clears `extPending` on the next clock. While no `svcDone` is given, a set `extPending` stays set. If the enabled carrier latch differs from the synchronized pin after service, `extPending` is set again on the following clock.
- R10: Status bit 2 (transmit empty) is 1 on the clock after `txFull` and `crcSending` are both low. It is 0 on the clock after either of them is high.
- R11: Status bit 0 is 1 on the clock after `rxLevel` is nonzero. It is 0 on the clock after `rxLevel` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| carrierPin | input | 1 | Asynchronous carrier-detect input |
| zeroCnt | input | 1 | High while the baud counter is at zero |
| txFull | input | 1 | Transmit buffer holds a character |
| crcSending | input | 1 | CRC is being transmitted |
| rxLevel | input | RX_LEVEL_W | Receive FIFO fill level |
| carrierIe | input | 1 | Carrier-detect interrupt enable |
| zeroCntIe | input | 1 | Zero-count interrupt enable |
| svcDone | input | 1 | Host pulse: reset external/status interrupt |
| statusReg | output | 4 | {carrier, tx empty, zero count, rx available} |
| extPending | output | 1 | External/status interrupt pending |

## Verification
The assertions check on every clock the one-cycle relations of the transmit-empty, receive-available and zero-count bits. They also check that the carrier bit stays frozen while an interrupt is pending and enabled, that a zero-count edge raises an interrupt when nothing is pending, and that the pending flag holds until service and clears after it. Deferral needs multi-step scenarios that only the bench can show: a zero-count edge held across a service cycle, either kept or dropped, and a carrier change that is replayed after the latch reopens. The random phase compares every clock against a bench model of the rules.

// File: rtl/ext_stat_pkg.sv
package ext_stat_pkg;
  // status word bit positions (host decodes these)
  localparam int STAT_RX  = 0;
  localparam int STAT_ZC  = 1;
  localparam int STAT_TXE = 2;
  localparam int STAT_CD  = 3;
  localparam int STAT_W   = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic holdLatch;   // latches closed while pending
  } ctlStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic cdDiffers;   // synchronized carrier differs from latched copy
    logic zcLive;      // enabled zero-count level
    logic zcRise;      // enabled zero-count rising edge
  } dpEvent_t;
endpackage

// File: rtl/ext_stat_dp.sv
module ext_stat_dp
  import ext_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RX_LEVEL_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  carrierPin,
  input  logic                  zeroCnt,
  input  logic                  txFull,
  input  logic                  crcSending,
  input  logic [RX_LEVEL_W-1:0] rxLevel,
  input  logic                  carrierIe,
  input  logic                  zeroCntIe,
  input  ctlStrobe_t            strobe,
  output dpEvent_t              events,
  output logic [STAT_W-1:0]     statusReg
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] cdPipe;
  logic              cdSync;
  logic              cdLatch;
  logic              zcPrev;
  logic              txEmpty;
  logic              rxAvail;
  logic              zcNow;

  generate
    if (SYNC_STAGES < 2) begin : g_syncOne
      always_ff @(posedge clk) begin
        if (rst) cdPipe <= '0;
        else     cdPipe <= carrierPin;
      end
    end else begin : g_syncChain
      always_ff @(posedge clk) begin
        if (rst) cdPipe <= '0;
        else     cdPipe <= {cdPipe[SYNC_MSB-1:0], carrierPin};
      end
    end
  endgenerate

  assign cdSync = cdPipe[SYNC_MSB];
  assign zcNow  = zeroCntIe & zeroCnt;

  // carrier latch: tracks while open, frozen while pending
  always_ff @(posedge clk) begin
    if (rst)                   cdLatch <= 1'b0;
    else if (!strobe.holdLatch) cdLatch <= cdSync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zcPrev  <= 1'b0;
      txEmpty <= 1'b1;
      rxAvail <= 1'b0;
    end else begin
      zcPrev  <= zcNow;
      txEmpty <= ~(txFull | crcSending);
      rxAvail <= (rxLevel != '0);
    end
  end

  assign events.cdDiffers = cdSync ^ cdLatch;
  assign events.zcLive    = zcNow;
  assign events.zcRise    = zcNow & ~zcPrev;

  always_comb begin
    statusReg           = '0;
    statusReg[STAT_RX]  = rxAvail;
    statusReg[STAT_ZC]  = zcPrev;
    statusReg[STAT_TXE] = txEmpty;
    statusReg[STAT_CD]  = carrierIe ? cdLatch : cdSync;
  end
endmodule

// File: rtl/ext_stat_ctl.sv
module ext_stat_ctl
  import ext_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       carrierIe,
  input  logic       svcDone,
  input  dpEvent_t   events,
  output ctlStrobe_t strobe,
  output logic       extPending
);
  logic zcDefer;
  logic cdCause;
  logic zcCause;
  logic raise;

  assign cdCause = carrierIe & events.cdDiffers;
  assign zcCause = events.zcLive & (events.zcRise | zcDefer);
  assign raise   = ~extPending & (cdCause | zcCause);

  always_ff @(posedge clk) begin
    if (rst)          extPending <= 1'b0;
    else if (raise)   extPending <= 1'b1;
    else if (svcDone) extPending <= 1'b0;
  end

  // a zero-count edge seen while pending is kept until service ends,
  // then examined once against the live level
  always_ff @(posedge clk) begin
    if (rst)             zcDefer <= 1'b0;
    else if (extPending) zcDefer <= zcDefer | events.zcRise;
    else                 zcDefer <= 1'b0;
  end

  assign strobe.holdLatch = extPending;
endmodule

// File: rtl/ext_stat_latch.sv
module ext_stat_latch
  import ext_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RX_LEVEL_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  carrierPin,
  input  logic                  zeroCnt,
  input  logic                  txFull,
  input  logic                  crcSending,
  input  logic [RX_LEVEL_W-1:0] rxLevel,
  input  logic                  carrierIe,
  input  logic                  zeroCntIe,
  input  logic                  svcDone,
  output logic [3:0]            statusReg,
  output logic                  extPending
);
  ctlStrobe_t strobe;
  dpEvent_t   events;

  ext_stat_dp #(.SYNC_STAGES(SYNC_STAGES), .RX_LEVEL_W(RX_LEVEL_W)) u_dp (
    .clk(clk), .rst(rst), .carrierPin(carrierPin), .zeroCnt(zeroCnt),
    .txFull(txFull), .crcSending(crcSending), .rxLevel(rxLevel),
    .carrierIe(carrierIe), .zeroCntIe(zeroCntIe), .strobe(strobe),
    .events(events), .statusReg(statusReg)
  );

  ext_stat_ctl u_ctl (
    .clk(clk), .rst(rst), .carrierIe(carrierIe), .svcDone(svcDone),
    .events(events), .strobe(strobe), .extPending(extPending)
  );
endmodule

// File: rtl/ext_stat_chk.sv
module ext_stat_chk #(
  parameter int RX_LEVEL_W = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  zeroCnt,
  input logic                  txFull,
  input logic                  crcSending,
  input logic [RX_LEVEL_W-1:0] rxLevel,
  input logic                  carrierIe,
  input logic                  zeroCntIe,
  input logic                  svcDone,
  input logic [3:0]            statusReg,
  input logic                  extPending
);
  // R10
  tx_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (txFull || crcSending) |=> !statusReg[2]);
  // R10
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(txFull || crcSending) |=> statusReg[2]);
  // R11
  rx_avail_chk: assert property (@(posedge clk) disable iff (rst)
    (rxLevel != '0) |=> statusReg[0]);
  // R11
  rx_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rxLevel == '0) |=> !statusReg[0]);
  // R5
  zc_on_chk: assert property (@(posedge clk) disable iff (rst)
    (zeroCntIe && zeroCnt) |=> statusReg[1]);
  // R5
  zc_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(zeroCntIe && zeroCnt) |=> !statusReg[1]);
  // R6
  zc_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (!extPending && zeroCntIe && zeroCnt && !statusReg[1]) |=> extPending);
  // R4
  cd_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (extPending && carrierIe) |=> (!extPending || !carrierIe || $stable(statusReg[3])));
  // R9
  svc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (extPending && svcDone) |=> !extPending);
  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (extPending && !svcDone) |=> extPending);
endmodule

bind ext_stat_latch ext_stat_chk #(.RX_LEVEL_W(RX_LEVEL_W)) u_chk (
  .clk(clk), .rst(rst), .zeroCnt(zeroCnt), .txFull(txFull),
  .crcSending(crcSending), .rxLevel(rxLevel), .carrierIe(carrierIe),
  .zeroCntIe(zeroCntIe), .svcDone(svcDone), .statusReg(statusReg),
  .extPending(extPending)
);

// File: tb/ext_stat_latch_tb.sv
module ext_stat_latch_tb;
  localparam int RXW = 5;
  localparam time CLK_T = 20ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carrierPin = 0, zeroCnt = 0, txFull = 0, crcSending = 0;
  logic [RXW-1:0] rxLevel = '0;
  logic carrierIe = 0, zeroCntIe = 0, svcDone = 0;
  logic [3:0] statusReg;
  logic extPending;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_T/2) clk = ~clk;

  ext_stat_latch #(.SYNC_STAGES(2), .RX_LEVEL_W(RXW)) u_dut (
    .clk(clk), .rst(rst), .carrierPin(carrierPin), .zeroCnt(zeroCnt),
    .txFull(txFull), .crcSending(crcSending), .rxLevel(rxLevel),
    .carrierIe(carrierIe), .zeroCntIe(zeroCntIe), .svcDone(svcDone),
    .statusReg(statusReg), .extPending(extPending)
  );

  // reference model of the rules, advanced on each rising edge
  logic mP1, mP2, mLatch, mPend, mZcPrev, mDefer, mTx, mRx;

  function automatic logic [3:0] modelStatus(logic ie, logic latchV, logic syncV,
                                              logic tx, logic zc, logic rx);
    return {ie ? latchV : syncV, tx, zc, rx};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mP1 = 0; mP2 = 0; mLatch = 0; mPend = 0;
      mZcPrev = 0; mDefer = 0; mTx = 1; mRx = 0;
    end else begin
      logic live, rise, cause, nPend;
      live  = zeroCntIe & zeroCnt;
      rise  = live & ~mZcPrev;
      cause = ~mPend & ((carrierIe & (mP2 ^ mLatch)) | (live & (rise | mDefer)));
      nPend = cause ? 1'b1 : (svcDone ? 1'b0 : mPend);
      mDefer  = mPend ? (mDefer | rise) : 1'b0;
      if (!mPend) mLatch = mP2;
      mPend   = nPend;
      mP2     = mP1;
      mP1     = carrierPin;
      mZcPrev = live;
      mTx     = ~(txFull | crcSending);
      mRx     = (rxLevel != '0);
    end
  end

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic service();
    svcDone = 1; tick(1); svcDone = 0;
  endtask

  initial begin
    #(CLK_T * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R1 reset state
    check("R1 pending", {3'b0, extPending}, 4'd0);
    check("R1 status", statusReg, 4'b0100);

    // R10 transmit empty
    txFull = 1; tick(1); check("R10 full", {3'b0, statusReg[2]}, 4'd0);
    txFull = 0; crcSending = 1; tick(1); check("R10 crc", {3'b0, statusReg[2]}, 4'd0);
    crcSending = 0; tick(1); check("R10 idle", {3'b0, statusReg[2]}, 4'd1);

    // R11 receive available
    rxLevel = 3; tick(1); check("R11 some", {3'b0, statusReg[0]}, 4'd1);
    rxLevel = '1; tick(1); check("R11 full", {3'b0, statusReg[0]}, 4'd1);
    rxLevel = 0; tick(1); check("R11 empty", {3'b0, statusReg[0]}, 4'd0);

    // R2 carrier live when disabled
    carrierPin = 1; tick(1);
    check("R2 sync delay", {3'b0, statusReg[3]}, 4'd0);
    tick(1); check("R2 live", {3'b0, statusReg[3]}, 4'd1);
    tick(2); check("R2 no irq", {3'b0, extPending}, 4'd0);

    // R3 carrier change raises interrupt
    carrierIe = 1; carrierPin = 0; tick(2);
    check("R3 before", {2'b0, extPending, statusReg[3]}, 4'b0001);
    tick(1);
    check("R3 raised", {2'b0, extPending, statusReg[3]}, 4'b0010);

    // R4 frozen while pending
    carrierPin = 1; tick(3);
    check("R4 frozen", {2'b0, extPending, statusReg[3]}, 4'b0010);

    // R9 service then replay of the changed carrier
    service();
    check("R9 cleared", {3'b0, extPending}, 4'd0);
    tick(1);
    check("R9 replay", {2'b0, extPending, statusReg[3]}, 4'b0011);
    service(); tick(2);
    check("R9 stays clear", {3'b0, extPending}, 4'd0);

    // R5 enable gates zero count
    zeroCnt = 1; tick(2);
    check("R5 disabled", {2'b0, extPending, statusReg[1]}, 4'b0000);
    zeroCnt = 0; tick(1);

    // R6 zero count raises when idle
    zeroCntIe = 1; zeroCnt = 1; tick(1);
    check("R6 raised", {2'b0, extPending, statusReg[1]}, 4'b0011);
    zeroCnt = 0; tick(1);
    check("R5 unlatched", {2'b0, extPending, statusReg[1]}, 4'b0010);
    service(); tick(1);
    check("R6 no repeat", {3'b0, extPending}, 4'd0);

    // R7 deferred and kept
    carrierPin = 0; tick(3);
    check("R7 setup", {3'b0, extPending}, 4'd1);
    zeroCnt = 1; tick(1);
    check("R7 held", {2'b0, extPending, statusReg[1]}, 4'b0011);
    service();
    check("R7 gap", {3'b0, extPending}, 4'd0);
    tick(1);
    check("R7 raised", {3'b0, extPending}, 4'd1);
    service(); tick(1);
    check("R7 once", {2'b0, extPending, statusReg[1]}, 4'b0001);

    // R8 deferred and dropped
    zeroCnt = 0; tick(1);
    carrierPin = 1; tick(3);
    check("R8 setup", {3'b0, extPending}, 4'd1);
    zeroCnt = 1; tick(1);
    zeroCnt = 0; tick(1);
    service(); tick(2);
    check("R8 dropped", {3'b0, extPending}, 4'd0);

    // random phase against the model
    rst = 1; tick(2); rst = 0;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 5)  carrierPin = ~carrierPin;
      if ($urandom_range(99) < 10) zeroCnt = ~zeroCnt;
      if ($urandom_range(99) < 3)  carrierIe = ~carrierIe;
      if ($urandom_range(99) < 3)  zeroCntIe = ~zeroCntIe;
      svcDone    = ($urandom_range(99) < 8);
      txFull     = $urandom_range(1);
      crcSending = ($urandom_range(99) < 10);
      rxLevel    = ($urandom_range(3) == 0) ? '0 : RXW'($urandom);
      tick(1);
      check("R3/R7 model pending", {3'b0, extPending}, {3'b0, mPend});
      check("R4/R10 model status", statusReg,
            modelStatus(carrierIe, mLatch, mP2, mTx, mZcPrev, mRx));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule